// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block keeps track of which power mode a small microcontroller core is in, and it drives the clock gates and status flags that follow from that mode. It recognises two active modes and four low-power modes. The active modes are NORMAL, which runs from the high-speed oscillator, and SLOW, which runs from the low-speed internal oscillator. The low-power modes are SLEEP0, SLEEP1, IDLE0 and IDLE1. The core's clock-control register bits and the HALT strobe are fed straight into the block. The block then decides which mode comes next.

When software writes a clock selection that needs the high-speed oscillator, the block leaves SLOW only once the oscillator reports that it is ready. On HALT, the low-power mode is chosen from three inputs: the idle-enable bit, the keep-system-clock bit and the watchdog and low-voltage-detect enables. A wake-up event brings the core back to the active mode it was in before HALT. Going back to high-speed clocking again waits for oscillator ready. Entering the deepest sleep pulses a watchdog clear, sets the power-down flag and clears the time-out flag.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, mode_o is NORMAL and pdf_o and to_o are 0. The mode codes on mode_o are 0 NORMAL, 1 SLOW, 2 SLEEP0, 3 SLEEP1, 4 IDLE0 and 5 IDLE1.
- R2: In NORMAL with no HALT, the mode becomes SLOW on the next clock when the clock bit is 0 and the 3-bit select is 000 or 001.
- R3: In SLOW, the mode becomes NORMAL on the next clock only when hosc_ready_i is 1 and a fast selection is present. A fast selection is the clock bit at 1, or the clock bit at 0 with a select of 010 to 111. Otherwise the mode stays SLOW.
- R4: HALT in an active mode with idle enable 0 and both watchdog and LVD disabled enters SLEEP0.
- R5: HALT in an active mode with idle enable 0 and the watchdog or LVD enabled enters SLEEP1.
- R6: HALT in an active mode with idle enable 1 enters IDLE0 when the keep-system-clock bit is 0, and IDLE1 when it is 1.
- R7: The gates {system, peripheral/time-base, watchdog} follow the mode: NORMAL and SLOW 111, SLEEP0 000, SLEEP1 001, IDLE0 011, IDLE1 111. hs_clk_sel_o is 1 in NORMAL, and in IDLE1 when HALT was taken from NORMAL. It is 0 in every other case.
- R8: In the first SLEEP0 cycle, wdt_clr_o is 1 for exactly one cycle, pdf_o is 1 and to_o is 0.
- R9: A wake in a low-power mode returns to SLOW when HALT was taken from SLOW. When HALT was taken from NORMAL, a wake returns to NORMAL if hosc_ready_i is 1, and otherwise to SLOW.
- R10: HALT is ignored in low-power modes, and wake is ignored in active modes. HALT takes priority over a clock-select change in the same cycle.
- R11: A watchdog time-out input sets to_o, which holds until SLEEP0 entry or reset. pdf_o holds until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hlclk_i | input | 1 | High/low clock source bit |
| cks_i | input | 3 | Clock divider select |
| idle_en_i | input | 1 | HALT goes to idle rather than sleep |
| sysclk_on_i | input | 1 | Keep the system clock running in idle |
| wdt_en_i | input | 1 | Watchdog enabled |
| lvd_en_i | input | 1 | Low-voltage detector enabled |
| halt_i | input | 1 | HALT strobe |
| hosc_ready_i | input | 1 | High-speed oscillator stable |
| wake_i | input | 1 | Wake-up event |
| wdt_to_i | input | 1 | Watchdog time-out event |
| mode_o | output | 3 | Current mode code |
| sys_clk_en_o | output | 1 | System clock enable |
| periph_clk_en_o | output | 1 | Peripheral/time-base clock enable |
| wdt_clk_en_o | output | 1 | Watchdog clock enable |
| hs_clk_sel_o | output | 1 | High-speed clock selected |
| wdt_clr_o | output | 1 | Watchdog clear pulse |
| pdf_o | output | 1 | Power-down flag |
| to_o | output | 1 | Watchdog time-out flag |

## Verification
The assertions check the following on every cycle:
- the mode never moves into NORMAL while the oscillator is not ready;
- SLEEP0 gates every clock;
- IDLE1 keeps the system clock running;
- the watchdog clear, power-down and time-out flags are correct on SLEEP0 entry;
- a low-power mode holds without a wake;
- the power-down flag is sticky.

Some behaviours depend on a history of inputs, and only the bench's scenarios show them:
- which low-power mode each HALT combination picks;
- the boundary between the slow and fast select codes;
- where a wake returns to;
- HALT winning over a clock switch.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  localparam int PM_MODE_W = 3;

  typedef enum logic [PM_MODE_W-1:0] {
    PM_NORMAL = 3'd0,
    PM_SLOW   = 3'd1,
    PM_SLEEP0 = 3'd2,
    PM_SLEEP1 = 3'd3,
    PM_IDLE0  = 3'd4,
    PM_IDLE1  = 3'd5
  } pm_mode_e;

  typedef struct packed {
    logic sys;
    logic periph;
    logic wdt;
  } pm_gate_t;

  function automatic logic pm_is_active(pm_mode_e m);
    return (m == PM_NORMAL) || (m == PM_SLOW);
  endfunction

  function automatic pm_gate_t pm_gates(pm_mode_e m);
    pm_gate_t g;
    case (m)
      PM_SLEEP0: g = '{sys: 1'b0, periph: 1'b0, wdt: 1'b0};
      PM_SLEEP1: g = '{sys: 1'b0, periph: 1'b0, wdt: 1'b1};
      PM_IDLE0:  g = '{sys: 1'b0, periph: 1'b1, wdt: 1'b1};
      default:   g = '{sys: 1'b1, periph: 1'b1, wdt: 1'b1};
    endcase
    return g;
  endfunction

  function automatic pm_mode_e pm_halt_target(logic idle_en, logic sysclk_on,
                                              logic wdt_en, logic lvd_en);
    if (idle_en)
      return sysclk_on ? PM_IDLE1 : PM_IDLE0;
    return (wdt_en || lvd_en) ? PM_SLEEP1 : PM_SLEEP0;
  endfunction

endpackage

// File: rtl/pmc_clk_decode.sv
module pmc_clk_decode #(
  parameter int CKS_W    = 3,
  parameter int SLOW_MAX = 1
) (
  input  logic             hlclk_i,
  input  logic [CKS_W-1:0] cks_i,
  output logic             want_fast_o
);
  localparam logic [CKS_W-1:0] SLOW_LIMIT = SLOW_MAX[CKS_W-1:0];

  function automatic logic fast_request(logic hl, logic [CKS_W-1:0] sel);
    return hl || (sel > SLOW_LIMIT);
  endfunction

  assign want_fast_o = fast_request(hlclk_i, cks_i);
endmodule

// File: rtl/pmc_halt_select.sv
module pmc_halt_select
  import pwr_mode_pkg::*;
(
  input  logic     idle_en_i,
  input  logic     sysclk_on_i,
  input  logic     wdt_en_i,
  input  logic     lvd_en_i,
  output pm_mode_e target_o
);
  assign target_o = pm_halt_target(idle_en_i, sysclk_on_i, wdt_en_i, lvd_en_i);
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
  import pwr_mode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     halt_i,
  input  logic     wake_i,
  input  logic     want_fast_i,
  input  logic     hosc_ready_i,
  input  pm_mode_e target_i,
  output pm_mode_e mode_o,
  output logic     ret_fast_o,
  output logic     enter_sleep0_o
);
  pm_mode_e mode_q, mode_d;
  logic     ret_q, ret_d;
  logic     active;

  assign active = pm_is_active(mode_q);

  always_comb begin
    mode_d = mode_q;
    ret_d  = ret_q;
    if (active) begin
      if (halt_i) begin
        ret_d  = (mode_q == PM_NORMAL);
        mode_d = target_i;
      end else if (mode_q == PM_NORMAL && !want_fast_i) begin
        mode_d = PM_SLOW;
      end else if (mode_q == PM_SLOW && want_fast_i && hosc_ready_i) begin
        mode_d = PM_NORMAL;
      end
    end else if (wake_i) begin
      mode_d = (ret_q && hosc_ready_i) ? PM_NORMAL : PM_SLOW;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PM_NORMAL;
      ret_q  <= 1'b1;
    end else begin
      mode_q <= mode_d;
      ret_q  <= ret_d;
    end
  end

  assign mode_o         = mode_q;
  assign ret_fast_o     = ret_q;
  assign enter_sleep0_o = active && halt_i && (target_i == PM_SLEEP0);
endmodule

// File: rtl/pmc_status.sv
module pmc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_sleep0_i,
  input  logic wdt_to_i,
  output logic pdf_o,
  output logic to_o,
  output logic wdt_clr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdf_o     <= 1'b0;
      to_o      <= 1'b0;
      wdt_clr_o <= 1'b0;
    end else begin
      wdt_clr_o <= enter_sleep0_i;
      if (enter_sleep0_i) begin
        pdf_o <= 1'b1;
        to_o  <= 1'b0;
      end else if (wdt_to_i) begin
        to_o  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int CKS_W    = 3,
  parameter int SLOW_MAX = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hlclk_i,
  input  logic [CKS_W-1:0] cks_i,
  input  logic             idle_en_i,
  input  logic             sysclk_on_i,
  input  logic             wdt_en_i,
  input  logic             lvd_en_i,
  input  logic             halt_i,
  input  logic             hosc_ready_i,
  input  logic             wake_i,
  input  logic             wdt_to_i,
  output logic [2:0]       mode_o,
  output logic             sys_clk_en_o,
  output logic             periph_clk_en_o,
  output logic             wdt_clk_en_o,
  output logic             hs_clk_sel_o,
  output logic             wdt_clr_o,
  output logic             pdf_o,
  output logic             to_o
);
  logic     want_fast;
  pm_mode_e halt_target;
  pm_mode_e mode;
  logic     ret_fast;
  logic     enter_sleep0;
  pm_gate_t gates;

  pmc_clk_decode #(.CKS_W(CKS_W), .SLOW_MAX(SLOW_MAX)) u_dec (
    .hlclk_i     (hlclk_i),
    .cks_i       (cks_i),
    .want_fast_o (want_fast)
  );

  pmc_halt_select u_sel (
    .idle_en_i   (idle_en_i),
    .sysclk_on_i (sysclk_on_i),
    .wdt_en_i    (wdt_en_i),
    .lvd_en_i    (lvd_en_i),
    .target_o    (halt_target)
  );

  pmc_mode_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .halt_i         (halt_i),
    .wake_i         (wake_i),
    .want_fast_i    (want_fast),
    .hosc_ready_i   (hosc_ready_i),
    .target_i       (halt_target),
    .mode_o         (mode),
    .ret_fast_o     (ret_fast),
    .enter_sleep0_o (enter_sleep0)
  );

  pmc_status u_stat (
    .clk            (clk),
    .rst_n          (rst_n),
    .enter_sleep0_i (enter_sleep0),
    .wdt_to_i       (wdt_to_i),
    .pdf_o          (pdf_o),
    .to_o           (to_o),
    .wdt_clr_o      (wdt_clr_o)
  );

  assign gates           = pm_gates(mode);
  assign mode_o          = mode;
  assign sys_clk_en_o    = gates.sys;
  assign periph_clk_en_o = gates.periph;
  assign wdt_clk_en_o    = gates.wdt;
  assign hs_clk_sel_o    = (mode == PM_NORMAL) || (mode == PM_IDLE1 && ret_fast);
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_o,
  input logic       hosc_ready_i,
  input logic       wake_i,
  input logic       sys_clk_en_o,
  input logic       periph_clk_en_o,
  input logic       wdt_clk_en_o,
  input logic       wdt_clr_o,
  input logic       pdf_o,
  input logic       to_o,
  input logic       enter_sleep0
);
  logic in_sleep0, low_power;
  assign in_sleep0 = (mode_o == 3'd2);
  assign low_power = (mode_o >= 3'd2);

  p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o <= 3'd5);

  p_fast_waits_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 3'd0 && !hosc_ready_i) |=> (mode_o != 3'd0));

  p_sleep0_gates_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_sleep0 |-> (!sys_clk_en_o && !periph_clk_en_o && !wdt_clk_en_o));

  p_idle1_sysclk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 3'd5) |-> sys_clk_en_o);

  p_sleep0_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    enter_sleep0 |=> (in_sleep0 && pdf_o && !to_o && wdt_clr_o));

  p_clr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr_o |=> !wdt_clr_o);

  p_lowpower_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (low_power && !wake_i) |=> $stable(mode_o));

  p_pdf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pdf_o |=> pdf_o);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .mode_o          (mode_o),
  .hosc_ready_i    (hosc_ready_i),
  .wake_i          (wake_i),
  .sys_clk_en_o    (sys_clk_en_o),
  .periph_clk_en_o (periph_clk_en_o),
  .wdt_clk_en_o    (wdt_clk_en_o),
  .wdt_clr_o       (wdt_clr_o),
  .pdf_o           (pdf_o),
  .to_o            (to_o),
  .enter_sleep0    (enter_sleep0)
);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hlclk_i = 1'b1, idle_en_i = 1'b0, sysclk_on_i = 1'b0;
  logic wdt_en_i = 1'b0, lvd_en_i = 1'b0, halt_i = 1'b0;
  logic hosc_ready_i = 1'b1, wake_i = 1'b0, wdt_to_i = 1'b0;
  logic [2:0] cks_i = 3'd0;
  logic [2:0] mode_o;
  logic sys_clk_en_o, periph_clk_en_o, wdt_clk_en_o, hs_clk_sel_o;
  logic wdt_clr_o, pdf_o, to_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .hlclk_i(hlclk_i), .cks_i(cks_i),
    .idle_en_i(idle_en_i), .sysclk_on_i(sysclk_on_i), .wdt_en_i(wdt_en_i),
    .lvd_en_i(lvd_en_i), .halt_i(halt_i), .hosc_ready_i(hosc_ready_i),
    .wake_i(wake_i), .wdt_to_i(wdt_to_i), .mode_o(mode_o),
    .sys_clk_en_o(sys_clk_en_o), .periph_clk_en_o(periph_clk_en_o),
    .wdt_clk_en_o(wdt_clk_en_o), .hs_clk_sel_o(hs_clk_sel_o),
    .wdt_clr_o(wdt_clr_o), .pdf_o(pdf_o), .to_o(to_o)
  );

  typedef struct packed {
    logic       hl;
    logic [2:0] cks;
    logic       idle;
    logic       sc;
    logic       wdt;
    logic       lvd;
    logic       halt;
    logic       rdy;
    logic       wake;
    logic [2:0] mode;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1}, // R2 to slow
    '{1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1}, // R2 001 stays slow
    '{1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1}, // R3 not ready
    '{1'b0, 3'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0}, // R3 010 ready
    '{1'b0, 3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1}, // R2
    '{1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1}, // R3 hl not ready
    '{1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0}, // R3
    '{1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd4}, // R6 idle0
    '{1'b1, 3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd4}, // R10 halt ignored
    '{1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0}, // R9 wake normal
    '{1'b1, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd5}, // R6 idle1
    '{1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0}, // R9
    '{1'b1, 3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 3'd3}, // R5 wdt
    '{1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1}, // R9 wake not ready
    '{1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1}, // R3
    '{1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0}, // R3
    '{1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 3'd3}, // R5 lvd, R10 priority
    '{1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0}, // R9
    '{1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd1}, // R2
    '{1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3'd5}, // R6 from slow
    '{1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1}, // R9 back to slow
    '{1'b1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 3'd1}, // R10 wake ignored
    '{1'b0, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0}  // R3 111
  };

  function automatic logic [2:0] exp_gates(logic [2:0] m);
    case (m)
      3'd2:    return 3'b000;
      3'd3:    return 3'b001;
      3'd4:    return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    @(negedge clk);
    hlclk_i = 1'b1; cks_i = 3'd0; idle_en_i = 1'b0; sysclk_on_i = 1'b0;
    wdt_en_i = 1'b0; lvd_en_i = 1'b0; halt_i = 1'b0; wake_i = 1'b0;
    hosc_ready_i = 1'b1; wdt_to_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [2:0] last_active;
    logic       exp_hs;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 mode", 8'(mode_o), 8'd0);
    check("R1 pdf/to", {6'd0, pdf_o, to_o}, 8'd0);
    check("R7 reset gates", {5'd0, sys_clk_en_o, periph_clk_en_o, wdt_clk_en_o}, 8'h7);
    @(negedge clk);
    rst_n = 1'b1;
    last_active = 3'd0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      hlclk_i = VECS[i].hl; cks_i = VECS[i].cks; idle_en_i = VECS[i].idle;
      sysclk_on_i = VECS[i].sc; wdt_en_i = VECS[i].wdt; lvd_en_i = VECS[i].lvd;
      halt_i = VECS[i].halt; hosc_ready_i = VECS[i].rdy; wake_i = VECS[i].wake;
      step();
      exp_hs = (VECS[i].mode == 3'd0) || (VECS[i].mode == 3'd5 && last_active == 3'd0);
      check($sformatf("R2-R6,R9,R10 mode row %0d", i), 8'(mode_o), 8'(VECS[i].mode));
      check($sformatf("R7 gates row %0d", i),
            {5'd0, sys_clk_en_o, periph_clk_en_o, wdt_clk_en_o}, 8'(exp_gates(VECS[i].mode)));
      check($sformatf("R7 hs_sel row %0d", i), 8'(hs_clk_sel_o), 8'(exp_hs));
      if (VECS[i].mode <= 3'd1) last_active = VECS[i].mode;
    end

    // R11 time-out flag set by input
    idle_inputs();
    wdt_to_i = 1'b1;
    step();
    check("R11 to set", 8'(to_o), 8'd1);
    // R4 / R8 SLEEP0 entry
    idle_inputs();
    halt_i = 1'b1;
    step();
    check("R4 sleep0", 8'(mode_o), 8'd2);
    check("R8 entry flags", {5'd0, wdt_clr_o, pdf_o, to_o}, 8'b110);
    check("R7 sleep0 gates", {5'd0, sys_clk_en_o, periph_clk_en_o, wdt_clk_en_o}, 8'd0);
    idle_inputs();
    step();
    check("R8 clr one cycle", 8'(wdt_clr_o), 8'd0);
    check("R10 sleep0 holds", 8'(mode_o), 8'd2);
    idle_inputs();
    wake_i = 1'b1;
    step();
    check("R9 wake from sleep0", 8'(mode_o), 8'd0);
    check("R11 pdf sticky", 8'(pdf_o), 8'd1);
    idle_inputs();
    rst_n = 1'b0;
    #1;
    check("R1 pdf after reset", 8'(pdf_o), 8'd0);
    check("R1 mode after reset", 8'(mode_o), 8'd0);
    finish_run();
  end
endmodule